// File: doc/BRIEF.md
# Link Test Pattern Checker

This block watches the raw receive word of an eight-lane serial converter link and confirms that the converter is sending one of its two built-in link test patterns. The `mode` input picks the pattern. Each lane occupies one 32-bit slice of the word. Within a slice, the earliest octet sits in bits 7:0 and later octets move toward the top.

In ramp mode, every lane carries the same free-running octet counter. In short transport mode, each lane repeats a two-word frame. The frame holds five 12-bit samples and a zero tail nibble, and every sample value encodes its lane number and its position in the frame.

The checker gives a registered per-lane error flag for every word it checks. It also provides a sticky error flag, a lock indication and a saturating error counter for each lane. It works directly on the raw word and does not need any sample unpacker in front of it.

Top module: `link_pattern_checker`

## Requirements
- R1: In ramp mode (`mode`=0), lane L is `data[32L+31:32L]`. Byte k of that slice (bits 8k+7:8k) must equal base+k modulo 256. The base for the next valid word is the previous base plus 4 modulo 256, so the count wraps from 0xFF to 0x00.
- R2: In ramp mode, all lanes are compared against one common expectation. A lane whose slice differs from the others raises only its own error bit.
- R3: The first valid word after `en` rises takes its ramp base from bits 7:0 of lane 0. That word is itself checked against the base.
- R4: In short transport mode (`mode`=1), sample s (1..5) of lane L is {4'(15-L), 4'(L), 4'(s)}. The 64-bit frame is the samples in order, most significant bit first, followed by a zero tail nibble. Octet k is frame bits 63-8k down to 56-8k. Half A carries octets 0..3 and half B carries octets 4..7, each with its first octet in bits 7:0.
- R5: On the first valid short-mode word after enable, the checker uses half B if lane 0 equals half B, and half A otherwise. After that the expected half alternates on every valid word.
- R6: `lane_err` is updated one clock after each valid enabled word, with bit L set when lane L mismatched. It reads zero after a clock with `valid` low.
- R7: `locked` rises with the fourth consecutive error-free valid word. It falls on any word that has an error.
- R8: Each lane has a 16-bit counter at `err_cnt[16L+15:16L]`. It adds one for each valid enabled word in which that lane mismatched, and it holds at 0xFFFF.
- R9: `sticky_err` is set by any lane error. Only `clr` removes it. `clr` also zeroes every counter and takes priority over an error in the same cycle.
- R10: While `en` is low, the seed, phase and lock are dropped and `lane_err` is zero. The counters and the sticky flag are kept.
- R11: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Checking enable; a rising edge restarts seeding |
| mode | input | 1 | 0 = octet ramp, 1 = short transport pattern |
| clr | input | 1 | Clears the sticky flag and the counters |
| valid | input | 1 | `data` holds a word to check |
| data | input | 256 | Raw receive word, 32 bits per lane |
| lane_err | output | 8 | Per-lane mismatch of the last checked word |
| sticky_err | output | 1 | Set by any error until cleared |
| locked | output | 1 | Four or more consecutive clean words |
| err_cnt | output | 128 | Saturating 16-bit error count per lane |

## Verification
The bench starts the ramp near 0xFA so that the wrap to 0x00 falls inside a word; a checker that wraps wrongly flags every lane. It corrupts a single lane to prove that errors stay on that lane, and it breaks the ramp step on all lanes at once. A design that reseeds from the incoming data would miss that broken step and stay quiet. In short mode the stream starts on the second half-frame, so a checker with a fixed phase flags every word. A corrupted tail nibble must be caught, and a long run of garbage drives the counters to their saturation value, where a design without a saturation guard wraps back to zero.

// File: rtl/ltp_pkg.sv
package ltp_pkg;

  localparam int LANE_W = 32;
  localparam int SMP_W  = 12;

  typedef enum logic {
    PAT_RAMP  = 1'b0,
    PAT_SHORT = 1'b1
  } pat_mode_e;

  // Sample s of a lane: {15-lane, lane, s}
  function automatic logic [SMP_W-1:0] st_sample(input int lane, input int idx);
    return {4'(15 - lane), 4'(lane), 4'(idx)};
  endfunction

  // One half-frame of the short pattern, earliest octet in bits 7:0
  function automatic logic [LANE_W-1:0] st_half(input int lane, input logic half_b);
    logic [SMP_W-1:0] s1, s2, s3, s4, s5;
    s1 = st_sample(lane, 1);
    s2 = st_sample(lane, 2);
    s3 = st_sample(lane, 3);
    s4 = st_sample(lane, 4);
    s5 = st_sample(lane, 5);
    if (!half_b)
      return {s3[11:4], s2[7:0], s1[3:0], s2[11:8], s1[11:4]};
    else
      return {s5[3:0], 4'h0, s5[11:4], s4[7:0], s3[3:0], s4[11:8]};
  endfunction

endpackage

// File: rtl/ltp_lane_cmp.sv
module ltp_lane_cmp
  import ltp_pkg::*;
#(
  parameter int LANE = 0
) (
  input  logic [LANE_W-1:0] word,
  input  logic [7:0]        base,
  output logic              ramp_bad,
  output logic              half_a_bad,
  output logic              half_b_bad
);

  localparam logic [LANE_W-1:0] EXP_A = st_half(LANE, 1'b0);
  localparam logic [LANE_W-1:0] EXP_B = st_half(LANE, 1'b1);

  logic [LANE_W-1:0] ramp_exp;

  always_comb begin
    for (int k = 0; k < LANE_W/8; k++)
      ramp_exp[8*k +: 8] = base + 8'(k);
  end

  assign ramp_bad   = (word != ramp_exp);
  assign half_a_bad = (word != EXP_A);
  assign half_b_bad = (word != EXP_B);

endmodule

// File: rtl/ltp_err_cnt.sv
module ltp_err_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (inc && cnt != TOP)
      cnt <= cnt + 1'b1;
  end

  assert_cnt_mono_R8: assert property (@(posedge clk) disable iff (rst)
    !clr |=> cnt >= $past(cnt));

  assert_cnt_sat_R8: assert property (@(posedge clk) disable iff (rst)
    (!clr && cnt == TOP) |=> cnt == TOP);

  assert_cnt_clr_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt == '0);

endmodule

// File: rtl/link_pattern_checker.sv
module link_pattern_checker
  import ltp_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int CNT_W  = 16,
  parameter int LOCK_N = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   mode,
  input  logic                   clr,
  input  logic                   valid,
  input  logic [LANE_W*LANES-1:0] data,
  output logic [LANES-1:0]       lane_err,
  output logic                   sticky_err,
  output logic                   locked,
  output logic [CNT_W*LANES-1:0] err_cnt
);

  localparam int RUN_W = $clog2(LOCK_N + 1);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(LOCK_N);

  logic             seeded;
  logic [7:0]       rbase;
  logic             ph;
  logic [RUN_W-1:0] run;

  logic [7:0]       base_use;
  logic             half_use;
  logic [LANES-1:0] r_bad, a_bad, b_bad, mism;
  logic             any_bad;
  logic [RUN_W-1:0] run_nx;
  logic             chk;

  assign chk      = en && valid;
  assign base_use = seeded ? rbase : data[7:0];
  assign half_use = seeded ? ph : !b_bad[0];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    ltp_lane_cmp #(.LANE(l)) u_cmp (
      .word       (data[LANE_W*l +: LANE_W]),
      .base       (base_use),
      .ramp_bad   (r_bad[l]),
      .half_a_bad (a_bad[l]),
      .half_b_bad (b_bad[l])
    );

    assign mism[l] = (mode == PAT_SHORT) ? (half_use ? b_bad[l] : a_bad[l]) : r_bad[l];

    ltp_err_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .clr (clr),
      .inc (chk && mism[l]),
      .cnt (err_cnt[CNT_W*l +: CNT_W])
    );
  end

  assign any_bad = |mism;
  assign run_nx  = any_bad ? '0 : ((run == RUN_TOP) ? run : run + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      seeded   <= 1'b0;
      rbase    <= '0;
      ph       <= 1'b0;
      run      <= '0;
      locked   <= 1'b0;
      lane_err <= '0;
    end else if (!en) begin
      seeded   <= 1'b0;
      run      <= '0;
      locked   <= 1'b0;
      lane_err <= '0;
    end else if (valid) begin
      seeded   <= 1'b1;
      rbase    <= base_use + 8'd4;
      ph       <= !half_use;
      run      <= run_nx;
      locked   <= (run_nx == RUN_TOP);
      lane_err <= mism;
    end else begin
      lane_err <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      sticky_err <= 1'b0;
    else if (chk && any_bad)
      sticky_err <= 1'b1;
  end

  assert_lock_clean_R7: assert property (@(posedge clk) disable iff (rst)
    locked |-> lane_err == '0);

  assert_lock_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (chk && any_bad) |=> !locked);

  assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (en && !valid) |=> lane_err == '0);

  assert_disable_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!locked && lane_err == '0));

  assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (sticky_err && !clr) |=> sticky_err);

  assert_sticky_clr_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> !sticky_err);

  assert_err_sets_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (lane_err != '0) |-> sticky_err || $past(clr));

endmodule

// File: tb/link_pattern_checker_tb.sv
module link_pattern_checker_tb;

  localparam int L = 8;

  logic clk = 0;
  logic rst = 1, en = 0, mode = 0, clr = 0, valid = 0;
  logic [255:0] data = '0;
  logic [7:0]   lane_err;
  logic         sticky_err, locked;
  logic [127:0] err_cnt;

  always #4 clk = ~clk;

  link_pattern_checker u_dut (
    .clk(clk), .rst(rst), .en(en), .mode(mode), .clr(clr), .valid(valid),
    .data(data), .lane_err(lane_err), .sticky_err(sticky_err),
    .locked(locked), .err_cnt(err_cnt)
  );

  int total = 0, bad = 0;

  // reference model state
  int   m_cnt [L];
  bit   m_sticky, m_lock, m_seeded, m_ph;
  int   m_run, m_base;
  logic [7:0] m_lerr;

  function automatic logic [31:0] ramp_word(int b);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) w[8*k +: 8] = 8'((b + k) % 256);
    return w;
  endfunction

  function automatic logic [31:0] st_word(int lane, bit hb);
    logic [63:0] f;
    logic [31:0] w;
    f = '0;
    for (int s = 1; s <= 5; s++)
      f[63-12*(s-1) -: 12] = {4'(15 - lane), 4'(lane), 4'(s)};
    for (int k = 0; k < 4; k++) w[8*k +: 8] = f[63 - 8*(4*(hb ? 1 : 0) + k) -: 8];
    return w;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < L; i++) m_cnt[i] = 0;
      m_sticky = 0; m_lock = 0; m_seeded = 0; m_ph = 0;
      m_run = 0; m_base = 0; m_lerr = 0;
    end else begin
      logic [7:0] mm;
      int bu;
      bit hu;
      mm = 0;
      bu = m_seeded ? m_base : int'(data[7:0]);
      hu = m_seeded ? m_ph : (data[31:0] == st_word(0, 1));
      for (int i = 0; i < L; i++)
        mm[i] = mode ? (data[32*i +: 32] != st_word(i, hu))
                     : (data[32*i +: 32] != ramp_word(bu));
      if (clr) begin
        for (int i = 0; i < L; i++) m_cnt[i] = 0;
        m_sticky = 0;
      end else if (en && valid) begin
        for (int i = 0; i < L; i++)
          if (mm[i] && m_cnt[i] < 65535) m_cnt[i]++;
        if (mm != 0) m_sticky = 1;
      end
      if (!en) begin
        m_seeded = 0; m_run = 0; m_lock = 0; m_lerr = 0;
      end else if (valid) begin
        m_lerr = mm;
        m_run = (mm != 0) ? 0 : (m_run < 4 ? m_run + 1 : 4);
        m_lock = (m_run == 4);
        m_seeded = 1;
        m_base = (bu + 4) % 256;
        m_ph = !hu;
      end else begin
        m_lerr = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk(lane_err == m_lerr, "R6 lane_err", lane_err, m_lerr);
    chk(locked == m_lock, "R7 locked", locked, m_lock);
    chk(sticky_err == m_sticky, "R9 sticky", sticky_err, m_sticky);
    for (int i = 0; i < L; i++)
      chk(err_cnt[16*i +: 16] == 16'(m_cnt[i]), "R8 counter", err_cnt[16*i +: 16], m_cnt[i]);
  endtask

  // apply inputs at a falling edge, then compare at the next falling edge
  task automatic tick(input logic v, input logic [255:0] d);
    valid = v;
    data = d;
    @(negedge clk);
    cmp_all();
  endtask

  function automatic logic [255:0] ramp_all(int b);
    logic [255:0] d;
    for (int i = 0; i < L; i++) d[32*i +: 32] = ramp_word(b);
    return d;
  endfunction

  function automatic logic [255:0] st_all(bit hb);
    logic [255:0] d;
    for (int i = 0; i < L; i++) d[32*i +: 32] = st_word(i, hb);
    return d;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int b;
    bit hb;
    logic [255:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk(lane_err == 0 && !locked && !sticky_err && err_cnt == 0, "R11 reset", {lane_err, locked}, 0);

    // R1/R3 ramp seeded near wrap
    en = 1; mode = 0; b = 250;
    for (int n = 0; n < 6; n++) begin
      tick(1, ramp_all(b));
      b = (b + 4) % 256;
    end
    chk(lane_err == 0, "R1 ramp wrap clean", lane_err, 0);
    chk(locked == 1, "R7 lock after clean run", locked, 1);
    tick(0, '0);
    chk(lane_err == 0, "R6 idle", lane_err, 0);

    // R2 one lane corrupted
    d = ramp_all(b); d[32*3 + 16 +: 8] ^= 8'h01;
    tick(1, d); b = (b + 4) % 256;
    chk(lane_err == 8'h08, "R2 single lane", lane_err, 8'h08);
    chk(!locked, "R7 lock drop", locked, 0);

    // R1 ramp step broken on every lane
    b = (b + 5) % 256;
    tick(1, ramp_all(b));
    chk(lane_err == 8'hFF, "R1 broken step", lane_err, 8'hFF);
    for (int n = 0; n < 3; n++) begin
      b = (b + 4) % 256;
      tick(1, ramp_all(b));
    end

    // R10/R3 re-enable reseeds
    en = 0; tick(1, ramp_all(7));
    chk(!locked && lane_err == 0, "R10 disabled", {locked, lane_err}, 0);
    chk(sticky_err, "R10 sticky kept", sticky_err, 1);
    en = 1; b = 100;
    for (int n = 0; n < 5; n++) begin
      tick(1, ramp_all(b));
      b = (b + 4) % 256;
    end
    chk(locked && lane_err == 0, "R3 reseed", {locked, lane_err}, 9'h100);

    // R9 clear
    clr = 1; tick(0, '0); clr = 0;
    chk(!sticky_err && err_cnt == 0, "R9 clear", sticky_err, 0);

    // R4/R5 short mode starting on half B
    en = 0; tick(0, '0);
    en = 1; mode = 1; hb = 1;
    for (int n = 0; n < 8; n++) begin
      tick(1, st_all(hb));
      hb = !hb;
    end
    chk(locked && lane_err == 0, "R5 phase from B", {locked, lane_err}, 9'h100);
    d = st_all(hb);
    if (hb) d[32*5 + 24 +: 4] = 4'h3;
    else d[32*5 +: 8] ^= 8'h10;
    tick(1, d); hb = !hb;
    chk(lane_err == 8'h20, "R4 lane5 corrupt", lane_err, 8'h20);
    tick(1, st_all(hb)); hb = !hb;
    if (!hb) begin
      d = st_all(1); d[32*5 + 24 +: 4] = 4'h9;
      tick(1, d); hb = !hb;
      chk(lane_err == 8'h20, "R4 tail nibble", lane_err, 8'h20);
    end

    // R8 saturation
    for (int n = 0; n < 65540; n++) tick(1, '0);
    chk(err_cnt[15:0] == 16'hFFFF, "R8 saturate", err_cnt[15:0], 16'hFFFF);
    chk(err_cnt[127:112] == 16'hFFFF, "R8 saturate lane7", err_cnt[127:112], 16'hFFFF);

    // R9 clear wins over error in same cycle
    clr = 1; tick(1, '0); clr = 0;
    chk(!sticky_err && err_cnt == 0, "R9 clear priority", sticky_err, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule